// File: doc/BRIEF.md
# Passive LCD AC Bias Generator with Transition Interrupt

This block drives the AC bias output of a passive LCD panel. It counts line-clock strobes and inverts the bias output once every programmed number of lines. This periodically reverses the drive polarity of the panel supply so that no DC charge builds up in the liquid crystal. When the panel needs no bias signal, software is expected to program the largest line count (255) to save power.

A second counter tallies bias transitions. Once it reaches a programmed number, it raises a sticky status flag that serves as an interrupt request. The counter stays frozen while the flag is high and starts again from zero after software pulses the clear input. In active-panel mode the output pin is held low. The line divider still produces transition events, so the transition count and the interrupt keep working as a line-based timer.

Top module: `lcd_acbias`

## Requirements
- R1: In passive mode (`active_mode`=0), `bias_out` inverts once every `toggle_cnt`+1 line strobes, for any value from 0 to 255. If `toggle_cnt` is lowered to a value at or below the lines already counted, the inversion happens on the next strobe.
- R2: `bias_out` changes only at the clock edge that samples `line_tick`=1. With no strobe it holds its value.
- R3: While `active_mode`=1, `bias_out` is 0 from the next edge onward. Transition events are still produced and counted for the status flag.
- R4: With `irq_cnt` nonzero, `stat_flag` rises at the same edge as the transition that brings the count since the last reset or clear up to `irq_cnt`.
- R5: `stat_flag` stays high until a clear pulse arrives, and transitions that occur while it is high are not counted.
- R6: A `stat_clr` pulse drops `stat_flag` at the next edge. Counting then starts again from zero, so a further `irq_cnt` transitions set the flag again.
- R7: With `irq_cnt`=0, the interrupt counter is disabled and `stat_flag` is never set.
- R8: If `stat_clr` and a set event fall on the same edge, the set wins and `stat_flag` stays high.
- R9: If `irq_cnt` is lowered to a value at or below the transitions already counted, `stat_flag` is set on the next transition.
- R10: Reset drives `bias_out` and `stat_flag` low and zeroes both counters. The first inversion then comes after `toggle_cnt`+1 strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_tick | input | 1 | One-cycle strobe per display line |
| toggle_cnt | input | 8 | Lines per bias inversion, minus one |
| irq_cnt | input | 4 | Transitions per status set; 0 disables |
| active_mode | input | 1 | 1 = active panel, bias pin held low |
| stat_clr | input | 1 | One-cycle clear of the status flag |
| bias_out | output | 1 | AC bias pin |
| stat_flag | output | 1 | Sticky status / interrupt request |

## Verification
Both outputs are registered once behind their inputs. A strobe or clear sampled at one rising edge shows its result on `bias_out` and `stat_flag` right after that same edge, so the result is due one cycle after the inputs are driven. The driver applies stimulus at a falling edge and waits for the rising edge. It then queues the expected pair from its own model of the requirements, and the monitor compares it at the next falling edge, well clear of any edge. Idle cycles are queued as well, which confirms that the outputs hold between strobes.

// File: rtl/acb_pkg.sv
package acb_pkg;
  parameter int unsigned LINE_W = 8;  // width of the lines-per-toggle setting
  parameter int unsigned EVT_W  = 4;  // width of the transitions-per-interrupt setting
endpackage

// File: rtl/acb_line_div.sv
// Counts line strobes and emits one event when the programmed count is reached.
module acb_line_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         evt
);
  logic [W-1:0] cnt_q, cnt_d;

  // >= so that a lowered limit wraps on the next strobe
  assign evt = tick && (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (evt) cnt_d = '0;
      else     cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/acb_pin_drv.sv
// Bias pin register: inverts on each event in passive mode, forced low in active mode.
module acb_pin_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic active,
  output logic pin
);
  logic pin_q, pin_d;

  always_comb begin
    if (active)   pin_d = 1'b0;
    else if (evt) pin_d = ~pin_q;
    else          pin_d = pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;
endmodule

// File: rtl/acb_evt_cnt.sv
// Counts bias events and raises a sticky flag after the programmed number.
module acb_evt_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic [W-1:0] limit,
  input  logic         clr,
  output logic         flag
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         flag_q, flag_d;
  logic [W:0]   inc;
  logic         enabled, hit, set;

  assign enabled = (limit != '0);
  assign inc     = {1'b0, cnt_q} + (W+1)'(1);
  assign hit     = inc >= {1'b0, limit};
  assign set     = enabled && evt && !flag_q && hit;

  always_comb begin
    cnt_d = cnt_q;
    if (!enabled)                 cnt_d = '0;
    else if (evt && !flag_q) begin
      if (hit) cnt_d = '0;
      else     cnt_d = inc[W-1:0];
    end
  end

  // set has priority over clear
  always_comb begin
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/lcd_acbias.sv
module lcd_acbias
  import acb_pkg::*;
#(
  parameter int unsigned ACB_W = LINE_W,
  parameter int unsigned API_W = EVT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_tick,
  input  logic [ACB_W-1:0] toggle_cnt,
  input  logic [API_W-1:0] irq_cnt,
  input  logic             active_mode,
  input  logic             stat_clr,
  output logic             bias_out,
  output logic             stat_flag
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   evt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  acb_line_div #(.W(ACB_W)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (line_tick),
    .limit (toggle_cnt),
    .evt   (evt)
  );

  acb_pin_drv u_pin (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .evt    (evt),
    .active (active_mode),
    .pin    (bias_out)
  );

  acb_evt_cnt #(.W(API_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_int_n),
    .evt   (evt),
    .limit (irq_cnt),
    .clr   (stat_clr),
    .flag  (stat_flag)
  );
endmodule

// File: rtl/acb_chk.sv
module acb_chk #(
  parameter int unsigned API_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_tick,
  input logic             active_mode,
  input logic [API_W-1:0] irq_cnt,
  input logic             stat_clr,
  input logic             bias_out,
  input logic             stat_flag
);
  // R3
  active_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_mode |=> !bias_out);

  // R2
  bias_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_tick && !active_mode) |=> $stable(bias_out));

  // R4
  flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_flag) |-> $past(line_tick));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flag && !stat_clr) |=> stat_flag);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flag && stat_clr) |=> !stat_flag);

  // R7
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cnt == '0 && !stat_flag) |=> !stat_flag);
endmodule

bind lcd_acbias acb_chk #(.API_W(API_W)) u_chk (.*);

// File: tb/lcd_acbias_tb.sv
module lcd_acbias_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_tick;
  logic [7:0] toggle_cnt;
  logic [3:0] irq_cnt;
  logic       active_mode;
  logic       stat_clr;
  logic       bias_out;
  logic       stat_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  int   r_lc;
  int   r_tc;
  logic r_bias;
  logic r_flag;

  always #5 clk = ~clk;

  lcd_acbias u_dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .toggle_cnt(toggle_cnt),
    .irq_cnt(irq_cnt), .active_mode(active_mode), .stat_clr(stat_clr),
    .bias_out(bias_out), .stat_flag(stat_flag)
  );

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {bias,flag} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: compares queued expectations at falling edges
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {bias_out, stat_flag}, e);
    end
  end

  // driver: one cycle of stimulus plus the expected outputs after the edge
  task automatic step(bit tk, bit cl, string tag);
    bit evt;
    bit set;
    @(negedge clk);
    line_tick = tk;
    stat_clr  = cl;
    evt = 0;
    set = 0;
    if (tk) begin
      if (r_lc >= int'(toggle_cnt)) begin r_lc = 0; evt = 1; end
      else r_lc++;
    end
    if (irq_cnt == 0) r_tc = 0;
    else if (evt && !r_flag) begin
      if (r_tc + 1 >= int'(irq_cnt)) begin set = 1; r_tc = 0; end
      else r_tc++;
    end
    if (active_mode) r_bias = 1'b0;
    else if (evt)    r_bias = ~r_bias;
    if (set)     r_flag = 1'b1;
    else if (cl) r_flag = 1'b0;
    @(posedge clk);
    #1;
    exp_q.push_back({r_bias, r_flag});
    tag_q.push_back(tag);
  endtask

  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) step(1, 0, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; line_tick = 0; stat_clr = 0; active_mode = 0;
    toggle_cnt = 8'd3; irq_cnt = 4'd0;
    r_lc = 0; r_tc = 0; r_bias = 0; r_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    check("R10", {bias_out, stat_flag}, 2'b00);

    // R1 R2 R7 R10: divide by 4, idle cycles between strobes, interrupt off
    for (int i = 0; i < 12; i++) begin
      step(1, 0, "R1");
      step(0, 0, "R2");
    end
    toggle_cnt = 8'd0;
    ticks(4, "R1");

    // R4 R5 R6: two transitions per set
    toggle_cnt = 8'd1;
    irq_cnt    = 4'd2;
    ticks(4, "R4");
    ticks(6, "R5");
    step(0, 1, "R6");
    ticks(4, "R6");
    step(0, 1, "R6");
    // R8: clear coincides with the setting transition
    ticks(3, "R8");
    step(1, 1, "R8");
    step(0, 0, "R8");
    step(0, 1, "R6");

    // R9: lower the limit below the count already reached
    toggle_cnt = 8'd0;
    irq_cnt    = 4'd4;
    ticks(2, "R9");
    irq_cnt    = 4'd2;
    step(1, 0, "R9");
    step(0, 1, "R9");

    // R3: active mode, pin low, interrupt still counts
    active_mode = 1;
    toggle_cnt  = 8'd1;
    irq_cnt     = 4'd3;
    ticks(8, "R3");
    step(0, 1, "R3");
    active_mode = 0;
    irq_cnt     = 4'd0;

    // R1: maximum divide and lowered limit
    toggle_cnt = 8'd255;
    ticks(512, "R1");
    toggle_cnt = 8'd5;
    ticks(3, "R1");
    toggle_cnt = 8'd1;
    ticks(3, "R1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule